// File: doc/BRIEF.md
# Serial NAND Power-Up Initialisation Sequencer

This block brings a serial NAND device into service after system reset, with no software involved. Once reset is released it drives the SPI bus on its own. It issues the device reset opcode twice and leaves a programmable idle gap after each one. It then waits a further settling interval and reads the two-byte device identifier. The identifier is compared against a parameterised list of supported parts.

When the part is supported, the block writes the block-protection feature register. A strap input chooses whether all blocks are left write-protected or the whole array is unlocked. Downstream logic waits for `ready` before it uses the flash. A part that is not on the list stops the sequence and raises a sticky error instead. In both cases the identifier that was read back stays visible on an output.

All waits are counted in clock cycles, so a fast simulation configuration only changes parameters. The SPI clock is produced by an internal byte shifter that works in mode 0.

Top module: `snand_boot_seq`

## Requirements
- R1: After reset is released, the first two SPI frames each carry exactly one byte, 0xFF.
- R2: After each reset frame, chip select stays high for at least RST_GAP_CYC cycles and at most RST_GAP_CYC+5 cycles. After the second reset frame, the gap before the identify frame is at least RST_GAP_CYC+SETTLE_CYC cycles and at most RST_GAP_CYC+SETTLE_CYC+8 cycles.
- R3: The third frame is four bytes long. It sends 0x9F and then 0x00. The two bytes read during byte slots 2 and 3 become the identifier, with slot 2 as bits 15:8.
- R4: `dev_id` shows the captured identifier after the identify frame, whether or not it matched, and holds it until reset.
- R5: Only identifiers in ID_LIST are accepted; the default list is 0x2C12 and 0x2C13. Any other identifier raises `no_dev_err`, keeps `ready` low and starts no further frame.
- R6: For an accepted identifier, the fourth frame is three bytes: 0x1F, 0xA0, then 0x38 when `ro_strap` is 1 or 0x00 when it is 0.
- R7: `ready` rises only after chip select has returned high at the end of the lock frame. It then stays high until reset, and it is never high together with `no_dev_err`.
- R8: `no_dev_err` stays high until the next reset.
- R9: While reset is asserted, including in the middle of a frame, chip select is high, SCK is low, and `ready`, `no_dev_err` and `dev_id` are zero.
- R10: The bus runs in SPI mode 0. SCK is low whenever chip select is high. Bytes go out MSB first, and MOSI is held steady while SCK is high, so that the device samples it on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ro_strap | input | 1 | 1 keeps all blocks protected; 0 unlocks the array |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| ready | output | 1 | Device identified and lock register written |
| no_dev_err | output | 1 | Sticky flag: identifier not supported |
| dev_id | output | 16 | Identifier captured from the device |

## Verification
The bench sweeps identifiers that sit one bit or one value away from the accepted pair, such as 0x2C11, 0x2C14, 0x2D12 and 0x2C92, under both strap values. A comparator that is too loose or too narrow would therefore flip the ready or error outcome for a near-miss identifier. A bus-level device model times every chip-select gap, so a sequencer that shortened a reset or settling wait, or merged two frames, breaks a gap window or the frame count. The model also checks the lock byte against the strap, which catches inverted or swapped protection values. The bench records the cycle in which `ready` first rises and the edge at which chip select returns high. A design that raised ready in the same cycle as that edge, or dropped its error flag later on, is reported, and so is a reset applied in the middle of the identify frame.

// File: rtl/snand_boot_pkg.sv
package snand_boot_pkg;

    localparam logic [7:0] OP_DEV_RESET  = 8'hFF;
    localparam logic [7:0] OP_READ_IDENT = 8'h9F;
    localparam logic [7:0] OP_SET_FEAT   = 8'h1F;
    localparam logic [7:0] FEAT_PROTECT  = 8'hA0;
    localparam logic [7:0] PROT_KEEP_ALL = 8'h38;
    localparam logic [7:0] PROT_OPEN_ALL = 8'h00;

    typedef enum logic [2:0] {
        ST_RST_TX,
        ST_RST_GAP,
        ST_SETTLE,
        ST_ID_TX,
        ST_ID_CHECK,
        ST_LOCK_TX,
        ST_READY,
        ST_NODEV
    } boot_st_e;

    typedef struct packed {
        boot_st_e    st;
        logic [1:0]  idx;
        logic        inflight;
        logic        cs_n;
        logic        pass;
        logic [15:0] id;
        logic        ready;
        logic        err;
    } boot_regs_t;

endpackage

// File: rtl/snand_shift.sv
module snand_shift #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic          done;
        logic [DW-1:0] div;
        logic [2:0]    bitc;
        logic [7:0]    sh;
        logic [7:0]    rx;
    } shift_regs_t;

    shift_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy = 1'b1;
                r_d.sh   = tx_byte;
                r_d.div  = '0;
                r_d.bitc = '0;
                r_d.sck  = 1'b0;
            end
        end else if (r_q.div == DIV_LAST) begin
            r_d.div = '0;
            if (!r_q.sck) begin
                r_d.sck = 1'b1;
                r_d.rx  = {r_q.rx[6:0], miso};
            end else begin
                r_d.sck = 1'b0;
                r_d.sh  = {r_q.sh[6:0], 1'b0};
                if (r_q.bitc == 3'd7) begin
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.bitc = r_q.bitc + 3'd1;
                end
            end
        end else begin
            r_d.div = r_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sck     = r_q.sck;
    assign mosi    = r_q.sh[7];
    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign rx_byte = r_q.rx;

    // R10: data line frozen during the high phase of SCK
    a_r10_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sck |-> $stable(r_q.sh[7]));

    // R10: a byte completes only on a falling SCK
    a_r10_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (!r_q.sck && $past(r_q.sck)));

endmodule

// File: rtl/snand_timer.sv
module snand_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R2: a running count only moves down by one or is reloaded
    a_r2_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/snand_id_match.sv
module snand_id_match #(
    parameter int                      NUM_IDS = 2,
    parameter logic [NUM_IDS*16-1:0]   ID_LIST = {16'h2C13, 16'h2C12}
) (
    input  logic [15:0] id,
    output logic        hit
);
    logic [NUM_IDS-1:0] eq;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_cmp
        assign eq[g] = (id == ID_LIST[g*16 +: 16]);
    end

    assign hit = |eq;

endmodule

// File: rtl/snand_boot_seq.sv
module snand_boot_seq
    import snand_boot_pkg::*;
#(
    parameter int                    SCK_HALF_DIV = 4,
    parameter int                    RST_GAP_CYC  = 25000,
    parameter int                    SETTLE_CYC   = 100000,
    parameter int                    NUM_IDS      = 2,
    parameter logic [NUM_IDS*16-1:0] ID_LIST      = {16'h2C13, 16'h2C12}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ro_strap,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        ready,
    output logic        no_dev_err,
    output logic [15:0] dev_id
);
    localparam int TMAX = (RST_GAP_CYC > SETTLE_CYC) ? RST_GAP_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    boot_regs_t q, n;

    logic          sh_start, sh_busy, sh_done;
    logic [7:0]    sh_tx, sh_rx;
    logic          tm_load, tm_exp;
    logic [TW-1:0] tm_val;
    logic          id_hit;
    logic          in_frame;
    logic [1:0]    last_idx;

    snand_shift #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    snand_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_exp)
    );

    snand_id_match #(.NUM_IDS(NUM_IDS), .ID_LIST(ID_LIST)) u_match (
        .id  (q.id),
        .hit (id_hit)
    );

    function automatic logic [7:0] frame_byte(boot_st_e st, logic [1:0] idx, logic ro);
        logic [7:0] b;
        b = 8'h00;
        case (st)
            ST_RST_TX:  b = OP_DEV_RESET;
            ST_ID_TX:   b = (idx == 2'd0) ? OP_READ_IDENT : 8'h00;
            ST_LOCK_TX: begin
                if (idx == 2'd0)      b = OP_SET_FEAT;
                else if (idx == 2'd1) b = FEAT_PROTECT;
                else                  b = ro ? PROT_KEEP_ALL : PROT_OPEN_ALL;
            end
            default:    b = 8'h00;
        endcase
        return b;
    endfunction

    always_comb begin
        in_frame = (q.st == ST_RST_TX) || (q.st == ST_ID_TX) || (q.st == ST_LOCK_TX);
        case (q.st)
            ST_ID_TX:   last_idx = 2'd3;
            ST_LOCK_TX: last_idx = 2'd2;
            default:    last_idx = 2'd0;
        endcase
    end

    always_comb begin
        n        = q;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        tm_load  = 1'b0;
        tm_val   = '0;

        if (in_frame) begin
            if (!q.inflight) begin
                if (!sh_busy) begin
                    sh_start   = 1'b1;
                    sh_tx      = frame_byte(q.st, q.idx, ro_strap);
                    n.inflight = 1'b1;
                    n.cs_n     = 1'b0;
                end
            end else if (sh_done) begin
                n.inflight = 1'b0;
                if (q.st == ST_ID_TX && q.idx == 2'd2) n.id[15:8] = sh_rx;
                if (q.st == ST_ID_TX && q.idx == 2'd3) n.id[7:0]  = sh_rx;
                if (q.idx == last_idx) begin
                    n.idx  = 2'd0;
                    n.cs_n = 1'b1;
                    case (q.st)
                        ST_RST_TX: begin
                            n.st    = ST_RST_GAP;
                            tm_load = 1'b1;
                            tm_val  = TW'(RST_GAP_CYC);
                        end
                        ST_ID_TX:  n.st = ST_ID_CHECK;
                        default:   n.st = ST_READY;
                    endcase
                end else begin
                    n.idx = q.idx + 2'd1;
                end
            end
        end else begin
            case (q.st)
                ST_RST_GAP: begin
                    if (tm_exp) begin
                        if (!q.pass) begin
                            n.pass = 1'b1;
                            n.st   = ST_RST_TX;
                        end else begin
                            n.st    = ST_SETTLE;
                            tm_load = 1'b1;
                            tm_val  = TW'(SETTLE_CYC);
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tm_exp) n.st = ST_ID_TX;
                end
                ST_ID_CHECK: begin
                    if (id_hit) begin
                        n.st = ST_LOCK_TX;
                    end else begin
                        n.st  = ST_NODEV;
                        n.err = 1'b1;
                    end
                end
                ST_READY: n.ready = 1'b1;
                ST_NODEV: n.err   = 1'b1;
                default:  n.st    = q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_RST_TX;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign spi_cs_n   = q.cs_n;
    assign ready      = q.ready;
    assign no_dev_err = q.err;
    assign dev_id     = q.id;

    a_r7_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (spi_cs_n && !spi_sck));

    a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r7_ready_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && no_dev_err));

    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        no_dev_err |=> (no_dev_err && $stable(dev_id)));

    a_r5_err_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        no_dev_err |-> spi_cs_n);

    a_r10_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r2_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RST_GAP || q.st == ST_SETTLE) |-> (spi_cs_n && !sh_busy));

endmodule

// File: tb/tb_snand_boot_seq.sv
module tb_snand_boot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int T_RST      = 20;
    localparam int T_SET      = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ro_strap = 1'b0;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso;
    logic        ready, no_dev_err;
    logic [15:0] dev_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    snand_boot_seq #(
        .SCK_HALF_DIV (HALF),
        .RST_GAP_CYC  (T_RST),
        .SETTLE_CYC   (T_SET)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ro_strap   (ro_strap),
        .spi_cs_n   (spi_cs_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .ready      (ready),
        .no_dev_err (no_dev_err),
        .dev_id     (dev_id)
    );

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    always @(posedge clk) cyc = cyc + 1;

    // device model
    logic [15:0] model_id = 16'h0000;
    logic [7:0]  fb [0:7][0:5];
    int          flen [0:7];
    longint      fall_t [0:7];
    longint      rise_t [0:7];
    int          fcount = 0;
    int          bidx = 0;
    int          bitn = 0;
    logic        fopen = 1'b0;
    logic [7:0]  shreg = 8'h00;
    int          sck_viol = 0;

    always @(negedge spi_cs_n) begin
        if (fcount < 8) fall_t[fcount] = cyc;
        bidx  = 0;
        bitn  = 0;
        fopen = 1'b1;
    end

    always @(posedge spi_cs_n) begin
        if (fopen) begin
            if (fcount < 8) begin
                rise_t[fcount] = cyc;
                flen[fcount]   = bidx;
            end
            fcount = fcount + 1;
            fopen  = 1'b0;
            bidx   = 0;
            bitn   = 0;
        end
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b1) sck_viol = sck_viol + 1;
        else begin
            shreg = {shreg[6:0], spi_mosi};
            bitn  = bitn + 1;
            if (bitn == 8) begin
                if (fcount < 8 && bidx < 6) fb[fcount][bidx] = shreg;
                bidx = bidx + 1;
                bitn = 0;
            end
        end
    end

    always @* begin
        spi_miso = 1'b0;
        if (spi_cs_n === 1'b0 && bitn < 8) begin
            if (bidx == 2)      spi_miso = model_id[15 - bitn];
            else if (bidx == 3) spi_miso = model_id[7 - bitn];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        fcount   = 0;
        sck_viol = 0;
        fopen    = 1'b0;
        for (int i = 0; i < 8; i++) begin
            flen[i] = 0;
            for (int j = 0; j < 6; j++) fb[i][j] = 8'h00;
        end
    endtask

    task automatic check_reset_state();
        chk(spi_cs_n === 1'b1, "R9", "cs_n in reset", longint'(spi_cs_n), 1);
        chk(spi_sck === 1'b0, "R9", "sck in reset", longint'(spi_sck), 0);
        chk(ready === 1'b0 && no_dev_err === 1'b0, "R9", "flags in reset",
            longint'({ready, no_dev_err}), 0);
        chk(dev_id === 16'h0000, "R9", "dev_id in reset", longint'(dev_id), 0);
    endtask

    task automatic run_case(input logic [15:0] id, input logic ro);
        bit     match;
        longint rdy_cyc;
        longint g01, g12;
        match = (id == 16'h2C12) || (id == 16'h2C13);
        @(negedge clk);
        rst_n    = 1'b0;
        model_id = id;
        ro_strap = ro;
        repeat (3) @(negedge clk);
        clear_model();
        check_reset_state();
        rst_n   = 1'b1;
        rdy_cyc = -1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (ready === 1'b1 || no_dev_err === 1'b1) begin
                rdy_cyc = cyc;
                break;
            end
        end
        repeat (60) @(negedge clk);

        chk(fcount == (match ? 4 : 3), "R5", "frame count", fcount, match ? 4 : 3);
        chk(flen[0] == 1 && fb[0][0] == 8'hFF, "R1", "first reset frame",
            longint'(fb[0][0]), 8'hFF);
        chk(flen[1] == 1 && fb[1][0] == 8'hFF, "R1", "second reset frame",
            longint'(fb[1][0]), 8'hFF);
        g01 = fall_t[1] - rise_t[0];
        g12 = fall_t[2] - rise_t[1];
        chk(g01 >= T_RST && g01 <= T_RST + 5, "R2", "gap after reset 1", g01, T_RST);
        chk(g12 >= T_RST + T_SET && g12 <= T_RST + T_SET + 8, "R2",
            "gap before identify", g12, T_RST + T_SET);
        chk(flen[2] == 4 && fb[2][0] == 8'h9F && fb[2][1] == 8'h00, "R3",
            "identify frame", longint'({fb[2][0], fb[2][1]}), 16'h9F00);
        chk(dev_id === id, "R4", "captured id", longint'(dev_id), longint'(id));
        chk(no_dev_err === !match, "R5", "error flag", longint'(no_dev_err), !match);
        chk(ready === match, "R7", "ready flag", longint'(ready), match);
        chk(sck_viol == 0, "R10", "sck while deselected", sck_viol, 0);
        if (match) begin
            chk(flen[3] == 3 && fb[3][0] == 8'h1F && fb[3][1] == 8'hA0, "R6",
                "lock frame header", longint'({fb[3][0], fb[3][1]}), 16'h1FA0);
            chk(fb[3][2] == (ro ? 8'h38 : 8'h00), "R6", "lock data byte",
                longint'(fb[3][2]), ro ? 8'h38 : 8'h00);
            chk(rdy_cyc > rise_t[3], "R7", "ready after cs release", rdy_cyc, rise_t[3] + 1);
        end
        // strap moved after completion must not disturb anything
        ro_strap = ~ro;
        repeat (200) @(negedge clk);
        chk(no_dev_err === !match && ready === match, "R8", "flags sticky",
            longint'({ready, no_dev_err}), longint'({match, !match}));
        chk(fcount == (match ? 4 : 3), "R7", "no frame after finish", fcount, match ? 4 : 3);
        chk(dev_id === id, "R4", "id held", longint'(dev_id), longint'(id));
    endtask

    logic [15:0] ids [0:9];

    initial begin
        ids[0] = 16'h2C12; ids[1] = 16'h2C13; ids[2] = 16'h2C11; ids[3] = 16'h2C14;
        ids[4] = 16'h0000; ids[5] = 16'hFFFF; ids[6] = 16'h2D12; ids[7] = 16'h2C92;
        ids[8] = 16'hAC13; ids[9] = 16'h2C1A;

        repeat (3) @(negedge clk);
        check_reset_state();

        // reset in the middle of the identify frame (R9)
        model_id = 16'h2C12;
        rst_n    = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (fcount == 2 && spi_cs_n === 1'b0) break;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R9", "mid-frame reset bus",
            longint'({spi_cs_n, spi_sck}), 2);

        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 10; i++)
                run_case(ids[i], s[0]);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule